// File: doc/BRIEF.md
# Non-stalling CPU-to-helper byte mailbox

This block lets a fast CPU pass bytes to a slower helper processor without the CPU ever waiting on its bus. A CPU write (strobe plus decoded select) lands in a holding register in one clock. The held byte stays there until the next CPU write replaces it. The helper samples that byte whenever it likes and then pulses its read strobe. The read raises a ready flag, `ack_irq`. The CPU can wire `ack_irq` straight to an interrupt input and send the next byte when it fires.

A three-state controller tracks the mailbox:

- `ST_EMPTY`: the helper has consumed the last byte, so `ack_irq` is high.
- `ST_HELD`: a byte is waiting.
- `ST_HELD_OVR`: a byte is waiting and the CPU wrote again before the helper read.

The transitions are:

- `T_LOAD`: EMPTY to HELD, on a write.
- `T_TAKE`: HELD to EMPTY, on a read with no write.
- `T_CLOBBER`: HELD to HELD_OVR, on a write.
- `T_REFILL`: HELD_OVR stays in HELD_OVR, on a write.
- `T_DRAIN`: HELD_OVR to EMPTY, on a read with no write.

A write in the same clock as a read wins, and the read is then discarded.

Top module: `wbp_port`

## Requirements
- R1: After reset `hlp_rdata` is 0x00, `ack_irq` is 1 and `overrun` is 0.
- R2: A write (`cpu_sel`=1 and `cpu_wr`=1 at a rising edge) makes `hlp_rdata` equal the written `cpu_wdata` from the next cycle on.
- R3: `cpu_wr`=1 with `cpu_sel`=0 is ignored: data, `ack_irq` and `overrun` keep their values.
- R4: With no write, `hlp_rdata` holds its value, including across helper reads and idle cycles.
- R5: A write from the empty state drops `ack_irq` to 0 in the next cycle, with `overrun` at 0.
- R6: A helper read (`hlp_rd`=1, no write) while a byte is held without overrun raises `ack_irq` in the next cycle.
- R7: A write while `ack_irq` is 0 overwrites the data, sets `overrun` to 1 and keeps `ack_irq` at 0.
- R8: A helper read with no write while `overrun` is 1 clears `overrun` and raises `ack_irq` in the next cycle.
- R9: When a write and a read coincide, the write wins. `ack_irq` goes to 0 and the data is the new byte. `overrun` becomes 1 if `ack_irq` was already 0, else 0.
- R10: A helper read while `ack_irq` is 1 and no write occurs changes nothing.
- R11: `ack_irq` and `overrun` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Decoded port select from the CPU side |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | Byte written by the CPU |
| hlp_rd | input | 1 | Helper read-done strobe |
| hlp_rdata | output | 8 | Held byte as seen by the helper |
| ack_irq | output | 1 | Ready for next byte; usable as an interrupt request |
| overrun | output | 1 | A held byte was overwritten before being read |

## Verification
The bench drives every ordered pair of the eight combinations of select, write and read. Each pair starts from each of the three controller states, so every transition and the write-over-read priority is reached from every state. Unselected writes and reads on an empty mailbox show that the ignore rules hold apart from real writes. Overlapping writes and reads show the priority rule apart from a plain overrun. A sweep of all 256 byte values through a write then a read shows that every data bit is latched and held independently.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY    = 2'd0,
        ST_HELD     = 2'd1,
        ST_HELD_OVR = 2'd2
    } wbp_state_t;
endpackage

// File: rtl/wbp_latch.sv
module wbp_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    held_q <= '0;
        else if (load) held_q <= din;
    end

    assign dout = held_q;
endmodule

// File: rtl/wbp_ctrl.sv
module wbp_ctrl
    import wbp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ev,
    input  logic rd_ev,
    output logic ready,
    output logic ovr
);
    wbp_state_t state_q, state_d;

    // next-state logic: a write always takes priority over a read
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:    if (wr_ev) state_d = ST_HELD;          // T_LOAD
            ST_HELD:     if (wr_ev) state_d = ST_HELD_OVR;      // T_CLOBBER
                         else if (rd_ev) state_d = ST_EMPTY;    // T_TAKE
            ST_HELD_OVR: if (wr_ev) state_d = ST_HELD_OVR;      // T_REFILL
                         else if (rd_ev) state_d = ST_EMPTY;    // T_DRAIN
            default:     state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        ready = 1'b0;
        ovr   = 1'b0;
        unique case (state_q)
            ST_EMPTY:    ready = 1'b1;
            ST_HELD:     ;
            ST_HELD_OVR: ovr   = 1'b1;
            default:     ready = 1'b1;
        endcase
    end
endmodule

// File: rtl/wbp_port.sv
module wbp_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              hlp_rd,
    output logic [DATA_W-1:0] hlp_rdata,
    output logic              ack_irq,
    output logic              overrun
);
    logic wr_ev;

    assign wr_ev = cpu_sel & cpu_wr;

    wbp_latch #(.W(DATA_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_ev),
        .din   (cpu_wdata),
        .dout  (hlp_rdata)
    );

    wbp_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_ev (wr_ev),
        .rd_ev (hlp_rd),
        .ready (ack_irq),
        .ovr   (overrun)
    );
endmodule

// File: rtl/wbp_port_chk.sv
module wbp_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_sel,
    input logic              cpu_wr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              hlp_rd,
    input logic [DATA_W-1:0] hlp_rdata,
    input logic              ack_irq,
    input logic              overrun
);
    a_r2_write_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_wr) |=> hlp_rdata == $past(cpu_wdata));

    a_r4_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_sel && cpu_wr) |=> $stable(hlp_rdata));

    a_r5_write_drops_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_wr) |=> !ack_irq);

    a_r7_write_while_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_wr && !ack_irq) |=> overrun);

    a_r8_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (hlp_rd && !(cpu_sel && cpu_wr) && !ack_irq) |=> (ack_irq && !overrun));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_irq && overrun));
endmodule

bind wbp_port wbp_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .hlp_rd    (hlp_rd),
    .hlp_rdata (hlp_rdata),
    .ack_irq   (ack_irq),
    .overrun   (overrun)
);

// File: tb/tb_wbp_port.sv
`timescale 1ns/1ps
module tb_wbp_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_sel = 1'b0, cpu_wr = 1'b0, hlp_rd = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] hlp_rdata;
    logic       ack_irq, overrun;

    int n_chk = 0, n_bad = 0, cycles = 0;

    // bench reference state
    logic [7:0] m_data = 8'h00;
    logic       m_full = 1'b0;
    logic       m_ovr  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    wbp_port dut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .hlp_rd(hlp_rd), .hlp_rdata(hlp_rdata),
        .ack_irq(ack_irq), .overrun(overrun)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag);
        n_chk++;
        if (hlp_rdata !== m_data || ack_irq !== !m_full || overrun !== m_ovr) begin
            n_bad++;
            $display("FAIL %s: actual data=%h ack=%b ovr=%b expected data=%h ack=%b ovr=%b",
                     tag, hlp_rdata, ack_irq, overrun, m_data, !m_full, m_ovr);
        end
        n_chk++;
        if (ack_irq && overrun) begin
            n_bad++;
            $display("FAIL R11: actual ack=1 ovr=1 expected not both");
        end
    endtask

    // one clock with given inputs, reference update, then compare
    task automatic step(input logic s, input logic w, input logic r, input logic [7:0] d);
        string tag;
        logic wev;
        @(negedge clk);
        cpu_sel = s; cpu_wr = w; hlp_rd = r; cpu_wdata = d;
        wev = s & w;
        if (w && !s)                 tag = "R3";
        else if (wev && r)           tag = "R9";
        else if (wev && m_full)      tag = "R7";
        else if (wev)                tag = "R5/R2";
        else if (r && m_full && m_ovr) tag = "R8";
        else if (r && m_full)        tag = "R6";
        else if (r)                  tag = "R10";
        else                         tag = "R4";
        @(posedge clk);
        if (wev) begin
            m_data = d;
            m_ovr  = m_full;
            m_full = 1'b1;
        end else if (r && m_full) begin
            m_full = 1'b0;
            m_ovr  = 1'b0;
        end
        #1;
        check(tag);
    endtask

    task automatic prime(input int st, input logic [7:0] d);
        step(1'b0, 1'b0, 1'b1, 8'h00);            // drain to empty
        if (st >= 1) step(1'b1, 1'b1, 1'b0, d ^ 8'h5A);
        if (st >= 2) step(1'b1, 1'b1, 1'b0, d);
    endtask

    initial begin
        #20;
        @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // all ordered pairs of (sel,wr,rd) from each controller state
        for (int st = 0; st < 3; st++)
            for (int p = 0; p < 8; p++)
                for (int q = 0; q < 8; q++) begin
                    prime(st, 8'((st * 29 + p * 37 + q * 11) & 255));
                    step(p[2], p[1], p[0], 8'((p * 53 + q * 7 + st) & 255));
                    step(q[2], q[1], q[0], 8'((q * 91 + p * 3 + 17) & 255));
                end

        // every byte value through a write then a read
        for (int v = 0; v < 256; v++) begin
            step(1'b1, 1'b1, 1'b0, 8'(v));   // R2
            step(1'b0, 1'b0, 1'b1, 8'(~v));  // R6, data held: R4
        end

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule